// File: doc/BRIEF.md
# Gamma Curve Register Loader

The block stores a twelve-entry table of 10-bit gamma control points and, on request, copies the whole table into a display panel's register file. The copy is a burst of fifteen 8-bit register writes, each handed to a separate serial write engine over a request/acknowledge port that carries a 6-bit register address and an 8-bit data byte. Only one write is outstanding at a time, and the loader moves to the next write only after the engine acknowledges the current one.

The two top bits of every point are gathered, four points to a byte, into three shared registers that go out first. The low bytes of the twelve points follow. Software changes single points through a point-write port while the loader is idle, then pulses the start input to push a consistent set. While an upload runs, the loader raises busy and ignores point writes and further start pulses. A one-cycle done pulse marks the end.

Top module: `gammaLoader`

## Requirements
- R1: After reset, busy, wrReq and doneOut are low and the table holds, for points 0 to 11, the values 106, 200, 289, 375, 460, 543, 625, 705, 785, 864, 942, 1020.
- R2: A startIn pulse while idle raises busy and wrReq in the next cycle, and the upload consists of exactly 15 acknowledged writes.
- R3: The first three writes go to addresses 0x11, 0x12, 0x13 in that order. Write g carries bits [9:8] of points 4g, 4g+1, 4g+2, 4g+3 in data bits [7:6], [5:4], [3:2], [1:0] respectively.
- R4: Writes four to fifteen go to addresses 0x14 to 0x1F in ascending order, and each carries bits [7:0] of points 0 to 11 respectively.
- R5: While wrReq is high and wrAck is low, wrReq stays high and wrAddr and wrData hold their values. A write completes only in a cycle with both wrReq and wrAck high.
- R6: doneOut is high for exactly one cycle: the cycle after the edge that samples the fifteenth acknowledge. wrReq is low in that cycle, and busy is low in the cycle after it.
- R7: A point write (ptWrEn high, ptWrIdx below 12) while idle replaces that point with ptWrData, and the next upload sends the new value.
- R8: ptWrEn and startIn are ignored while busy is high. The table and the running upload are unchanged, and no second upload follows.
- R9: A point write with ptWrIdx from 12 to 15 changes no point.
- R10: A point write in the same cycle as an idle startIn takes effect, and that upload already sends the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptWrEn | input | 1 | Point write strobe |
| ptWrIdx | input | 4 | Index of the point to write |
| ptWrData | input | 10 | New 10-bit point value |
| startIn | input | 1 | Start an upload of the whole table |
| busy | output | 1 | Upload in progress; point writes and start are ignored |
| doneOut | output | 1 | One-cycle pulse after the last write is acknowledged |
| wrReq | output | 1 | Register write request to the write engine |
| wrAddr | output | 6 | Register address of the current write |
| wrData | output | 8 | Data byte of the current write |
| wrAck | input | 1 | Write engine accepts the current write |

## Verification
The upload is first run on the reset table, then on all-ones and all-zero tables, which catch stuck or swapped two-bit slots in the packed bytes. It is then run on random tables, with random acknowledge delays that test the hold behaviour and the advance-on-acknowledge rule. Point writes and start pulses injected during busy separate an idle-only write path from one that leaks into a running upload. Out-of-range indices and a point write coinciding with start test the index check and the write-before-read ordering.

// File: rtl/gammaPkg.sv
package gammaPkg;
  localparam int STEP_W = 4;

  typedef struct packed {
    logic              tableWe;
    logic [STEP_W-1:0] step;
  } gammaCtl_t;
endpackage

// File: rtl/gammaTable.sv
module gammaTable
  import gammaPkg::*;
#(
  parameter int NUM_PTS = 12,
  parameter int PT_W    = 10,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int GRP     = 4,
  parameter int HI_BASE = 17,
  parameter int LO_BASE = 20,
  localparam int IDX_W  = $clog2(NUM_PTS),
  localparam int SLOT_W = PT_W - BYTE_W,
  localparam int NUM_HI = NUM_PTS / GRP
) (
  input  logic              clk,
  input  logic              rstN,
  input  gammaCtl_t         ctl,
  input  logic [IDX_W-1:0]  ptIdx,
  input  logic [PT_W-1:0]   ptData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  logic [PT_W-1:0]   pts    [NUM_PTS];
  logic [BYTE_W-1:0] hiByte [NUM_HI];

  function automatic logic [PT_W-1:0] defPoint(input int i);
    case (i)
      0: defPoint = PT_W'(106);   1: defPoint = PT_W'(200);
      2: defPoint = PT_W'(289);   3: defPoint = PT_W'(375);
      4: defPoint = PT_W'(460);   5: defPoint = PT_W'(543);
      6: defPoint = PT_W'(625);   7: defPoint = PT_W'(705);
      8: defPoint = PT_W'(785);   9: defPoint = PT_W'(864);
      10: defPoint = PT_W'(942);  default: defPoint = PT_W'(1020);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PTS; i++) pts[i] <= defPoint(i);
    end else if (ctl.tableWe) begin
      pts[ptIdx] <= ptData;
    end
  end

  // Pack the top bits: first point of a group lands in the most significant slot.
  for (genvar g = 0; g < NUM_HI; g++) begin : gHi
    for (genvar k = 0; k < GRP; k++) begin : gSlot
      assign hiByte[g][BYTE_W-1-k*SLOT_W -: SLOT_W] = pts[g*GRP+k][PT_W-1 -: SLOT_W];
    end
  end

  always_comb begin
    wrAddr = '0;
    wrData = '0;
    for (int s = 0; s < NUM_HI; s++) begin
      if (int'(ctl.step) == s) begin
        wrAddr = ADDR_W'(HI_BASE + s);
        wrData = hiByte[s];
      end
    end
    for (int i = 0; i < NUM_PTS; i++) begin
      if (int'(ctl.step) == NUM_HI + i) begin
        wrAddr = ADDR_W'(LO_BASE + i);
        wrData = pts[i][BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gammaSeq.sv
module gammaSeq
  import gammaPkg::*;
#(
  parameter int NUM_PTS = 12,
  parameter int NUM_HI  = 3,
  localparam int IDX_W  = $clog2(NUM_PTS),
  localparam int NUM_WR = NUM_HI + NUM_PTS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptWrEn,
  input  logic [IDX_W-1:0] ptWrIdx,
  input  logic             startIn,
  input  logic             wrAck,
  output gammaCtl_t        ctl,
  output logic             wrReq,
  output logic             busy,
  output logic             doneOut
);
  typedef enum logic [1:0] {IDLE, SEND, FIN} seqState_t;

  seqState_t         state;
  logic [STEP_W-1:0] step;
  logic              lastWr;

  assign lastWr = (int'(step) == NUM_WR - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
      step  <= '0;
    end else begin
      case (state)
        IDLE: if (startIn) begin
          state <= SEND;
          step  <= '0;
        end
        SEND: if (wrAck) begin
          if (lastWr) state <= FIN;
          else        step  <= step + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign wrReq       = (state == SEND);
  assign busy        = (state != IDLE);
  assign doneOut     = (state == FIN);
  assign ctl.step    = step;
  assign ctl.tableWe = ptWrEn && (state == IDLE) &&
                       ({1'b0, ptWrIdx} < (IDX_W+1)'(NUM_PTS));
endmodule

// File: rtl/gammaLoader.sv
module gammaLoader
  import gammaPkg::*;
#(
  parameter int NUM_PTS = 12,
  parameter int PT_W    = 10,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int GRP     = 4,
  parameter int HI_BASE = 17,
  parameter int LO_BASE = 20,
  localparam int IDX_W  = $clog2(NUM_PTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptWrEn,
  input  logic [IDX_W-1:0]  ptWrIdx,
  input  logic [PT_W-1:0]   ptWrData,
  input  logic              startIn,
  output logic              busy,
  output logic              doneOut,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  input  logic              wrAck
);
  gammaCtl_t ctl;

  gammaSeq #(.NUM_PTS(NUM_PTS), .NUM_HI(NUM_PTS / GRP)) uSeq (
    .clk(clk), .rstN(rstN), .ptWrEn(ptWrEn), .ptWrIdx(ptWrIdx),
    .startIn(startIn), .wrAck(wrAck), .ctl(ctl), .wrReq(wrReq),
    .busy(busy), .doneOut(doneOut)
  );

  gammaTable #(
    .NUM_PTS(NUM_PTS), .PT_W(PT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .GRP(GRP), .HI_BASE(HI_BASE), .LO_BASE(LO_BASE)
  ) uTable (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ptIdx(ptWrIdx), .ptData(ptWrData),
    .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/gammaLoaderChk.sv
module gammaLoaderChk #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int HI_BASE = 17,
  parameter int LAST_AD = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              busy,
  input logic              doneOut,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic              wrAck
);
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn && !busy |=> wrReq && busy && (wrAddr == ADDR_W'(HI_BASE)));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && $stable(wrAddr) && $stable(wrData));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrAck && (wrAddr != ADDR_W'(LAST_AD)) |=>
      wrReq && (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrAck && (wrAddr == ADDR_W'(LAST_AD)) |=> doneOut && !wrReq);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut && !busy);

  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> busy);
endmodule

bind gammaLoader gammaLoaderChk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .HI_BASE(HI_BASE),
  .LAST_AD(LO_BASE + NUM_PTS - 1)
) uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .busy(busy), .doneOut(doneOut),
  .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck)
);

// File: tb/gammaLoader_test.sv
module gammaLoader_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ptWrEn = 1'b0;
  logic [3:0] ptWrIdx = '0;
  logic [9:0] ptWrData = '0;
  logic       startIn = 1'b0;
  logic       wrAck = 1'b0;
  logic       busy, doneOut, wrReq;
  logic [5:0] wrAddr;
  logic [7:0] wrData;

  int nChecks = 0;
  int nFails  = 0;
  logic [9:0] model [12];

  always #4 clk = ~clk;

  gammaLoader uut (
    .clk(clk), .rstN(rstN), .ptWrEn(ptWrEn), .ptWrIdx(ptWrIdx),
    .ptWrData(ptWrData), .startIn(startIn), .busy(busy), .doneOut(doneOut),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] expAddr(input int k);
    return (k < 3) ? 6'(17 + k) : 6'(20 + k - 3);
  endfunction

  function automatic logic [7:0] expData(input int k);
    logic [7:0] d;
    if (k < 3) begin
      for (int j = 0; j < 4; j++) d[7-2*j -: 2] = model[k*4+j][9:8];
    end else begin
      d = model[k-3][7:0];
    end
    return d;
  endfunction

  // Idle point write; the model follows R7 and R9.
  task automatic ptWrite(input logic [3:0] idx, input logic [9:0] val);
    @(negedge clk);
    ptWrEn = 1'b1; ptWrIdx = idx; ptWrData = val;
    if (idx < 12) model[idx] = val;
    @(negedge clk);
    ptWrEn = 1'b0;
  endtask

  // One upload. withWr: point write in the start cycle (R10). noisy: random
  // ack delays with ignored writes and starts injected (R5, R8).
  task automatic upload(input bit noisy, input bit withWr,
                        input logic [3:0] wIdx, input logic [9:0] wVal);
    @(negedge clk);
    startIn = 1'b1;
    if (withWr) begin
      ptWrEn = 1'b1; ptWrIdx = wIdx; ptWrData = wVal;
      if (wIdx < 12) model[wIdx] = wVal;
    end
    @(negedge clk);
    startIn = 1'b0; ptWrEn = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    for (int k = 0; k < 15; k++) begin
      int dly;
      logic [5:0] a0;
      logic [7:0] d0;
      chk(wrReq === 1'b1, "R2", "wrReq", int'(wrReq), 1);
      chk(wrAddr === expAddr(k), (k < 3) ? "R3" : "R4", "wrAddr", int'(wrAddr), int'(expAddr(k)));
      chk(wrData === expData(k), (k < 3) ? "R3" : "R4", "wrData", int'(wrData), int'(expData(k)));
      a0 = wrAddr; d0 = wrData;
      dly = noisy ? int'($urandom % 4) : 0;
      for (int w = 0; w < dly; w++) begin
        ptWrEn = 1'b1; ptWrIdx = 4'($urandom % 12); ptWrData = 10'($urandom);
        startIn = 1'($urandom);
        @(negedge clk);
        ptWrEn = 1'b0; startIn = 1'b0;
        chk(wrReq === 1'b1 && wrAddr === a0 && wrData === d0, "R5",
            "hold without ack", int'({wrAddr, wrData}), int'({a0, d0}));
      end
      wrAck = 1'b1;
      @(negedge clk);
      wrAck = 1'b0;
    end
    chk(doneOut === 1'b1 && wrReq === 1'b0, "R6", "done after last ack",
        int'({doneOut, wrReq}), 2);
    @(negedge clk);
    chk(doneOut === 1'b0 && busy === 1'b0 && wrReq === 1'b0, "R6",
        "single done, idle again", int'({doneOut, busy, wrReq}), 0);
    @(negedge clk);
    chk(wrReq === 1'b0 && busy === 1'b0, "R8", "no second upload",
        int'({busy, wrReq}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 12; i++) begin
      int defs [12] = '{106, 200, 289, 375, 460, 543, 625, 705, 785, 864, 942, 1020};
      model[i] = 10'(defs[i]);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset, then default table through an upload
    chk(busy === 1'b0 && wrReq === 1'b0 && doneOut === 1'b0, "R1",
        "reset outputs", int'({busy, wrReq, doneOut}), 0);
    upload(1'b0, 1'b0, 4'd0, 10'd0);

    // R3 all ones, then all zeros
    for (int i = 0; i < 12; i++) ptWrite(4'(i), 10'h3FF);
    upload(1'b0, 1'b0, 4'd0, 10'd0);
    for (int i = 0; i < 12; i++) ptWrite(4'(i), 10'h000);
    upload(1'b1, 1'b0, 4'd0, 10'd0);

    // R3 single slot distinct per point
    for (int i = 0; i < 12; i++) ptWrite(4'(i), {2'(i % 4), 8'(i * 17)});
    upload(1'b0, 1'b0, 4'd0, 10'd0);

    // R9 out-of-range indices change nothing
    ptWrite(4'd12, 10'h155);
    ptWrite(4'd15, 10'h2AA);
    upload(1'b0, 1'b0, 4'd0, 10'd0);

    // R10 write coinciding with start
    upload(1'b0, 1'b1, 4'd0, 10'h2C3);
    upload(1'b1, 1'b1, 4'd11, 10'h1A5);

    // R7 R8 random tables with noisy uploads
    for (int r = 0; r < 20; r++) begin
      int n;
      n = 1 + int'($urandom % 6);
      for (int j = 0; j < n; j++) ptWrite(4'($urandom % 16), 10'($urandom));
      upload(1'b1, 1'($urandom), 4'($urandom % 16), 10'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule